// File: doc/BRIEF.md
# Reconfigurable Chaotic Euler-Step Random Source

This block integrates a three-variable chaotic system (x, y, z) with a forward Euler step every clock cycle. A 2-bit mode input picks one of four parameter sets: one Lorenz-style system and three Lü-style systems. All three state variables are 32-bit signed fixed point, with 8 integer bits and 24 fraction bits.

Only hardwired shifts, adders and multiplexers scale by the system constants and by the step size. The two cross products x·z and x·y use real signed multipliers. A host loads a seed triple with the init input, then reads a 24-bit pseudo-random word on every cycle. The word is made from the low byte of each state variable. The mode may be changed while the block runs.

Top module: `chaos_euler_prng`

## Requirements
- R1: While rst_ni is low, x_o, y_o, z_o and rand_o are all zero.
- R2: Each variable is Q8.24 two's complement. On every rising clock edge without init, each variable becomes current + (derivative >>> 8), an arithmetic shift. The derivative and the sum wrap modulo 2^32.
- R3: When init_i is high at a rising edge, the state loads seed_x_i, seed_y_i and seed_z_i. This overrides the Euler update.
- R4: dx = a·(y − x), where a = 8 for mode 00 and a = 32 for modes 01, 10 and 11.
- R5: dz = x·y − b·z, where b = 2 for mode 00 and b = 4 for the other modes.
- R6: In mode 00 (Lorenz-style), dy = 32·x − y − x·z.
- R7: In modes 01, 10 and 11 (Lü-style), dy = c·y − x·z, where c = 16, 12 and 20 respectively.
- R8: A cross product is the signed 64-bit product of the two Q8.24 operands, keeping bits [55:24]. Overflow wraps silently.
- R9: rand_o = {x_o[7:0], y_o[7:0], z_o[7:0]}, so x sits in the top byte.
- R10: The mode input may change on any cycle. The value present at a rising edge selects the equations for that edge's update only.
- R11: The all-zero state is a fixed point in every mode. With init low, it stays all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Load the seed triple on the next edge |
| cfg_i | input | 2 | Mode select: 00 Lorenz-style; 01, 10, 11 Lü-style |
| seed_x_i | input | 32 | Seed for x (Q8.24) |
| seed_y_i | input | 32 | Seed for y (Q8.24) |
| seed_z_i | input | 32 | Seed for z (Q8.24) |
| x_o | output | 32 | State x |
| y_o | output | 32 | State y |
| z_o | output | 32 | State z |
| rand_o | output | 24 | Low bytes of x, y, z |

## Verification
The bench runs long chaotic trajectories in each of the four modes against a bit-exact model. Any slip in a shift amount, in the Lorenz/Lü choice of the y-equation, or in the product slice makes the trajectory diverge within a few cycles.

Some seeds sit near full scale. They drive the sums and the products through wrap-around, so a design that saturates or keeps the wrong product bits shows up there.

The mode is switched every few cycles, which exposes a design that registers the mode and so applies it one step late. An init is issued in the middle of a run: a design that gives the Euler path priority over the seed load fails this case. An all-zero seed must stay at zero. A design with a bias term, or one that rounds instead of truncating, drifts away from zero.

// File: rtl/chaos_pkg.sv
package chaos_pkg;
  localparam int unsigned WIDTH     = 32;
  localparam int unsigned FRAC      = 24;
  localparam int unsigned STEP_SH   = 8;
  localparam int unsigned NVARS     = 3;
  localparam int unsigned TAP_BITS  = 8;
  localparam int unsigned RAND_BITS = NVARS * TAP_BITS;

  typedef enum logic [1:0] {
    MODE_LORENZ = 2'b00,
    MODE_LU_A   = 2'b01,
    MODE_LU_B   = 2'b10,
    MODE_LU_C   = 2'b11
  } mode_e;

  // constant shifts
  localparam int unsigned A_SH_LZ = 3;  // 8
  localparam int unsigned A_SH_LU = 5;  // 32
  localparam int unsigned B_SH_LZ = 1;  // 2
  localparam int unsigned B_SH_LU = 2;  // 4
  localparam int unsigned C_SH_LZ = 5;  // 32
  localparam int unsigned C_SH_HI = 4;  // 16
  localparam int unsigned C_SH_MD = 3;  // 8
  localparam int unsigned C_SH_LO = 2;  // 4
endpackage

// File: rtl/chaos_fx_mul.sv
module chaos_fx_mul #(
  parameter int unsigned W = 32,
  parameter int unsigned F = 24
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] p_o
);
  localparam int unsigned PW = 2 * W;

  logic signed [PW-1:0] full;
  logic                 unused_bits;

  assign full        = PW'(a_i) * PW'(b_i);
  assign p_o         = full[F+W-1:F];
  assign unused_bits = ^{full[PW-1:F+W], full[F-1:0]};
endmodule

// File: rtl/chaos_deriv.sv
module chaos_deriv
  import chaos_pkg::*;
#(
  parameter int unsigned W  = WIDTH,
  parameter int unsigned F  = FRAC,
  parameter int unsigned SH = STEP_SH
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  mode_e               mode_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  input  logic signed [W-1:0] z_i,
  output logic signed [W-1:0] hdx_o,
  output logic signed [W-1:0] hdy_o,
  output logic signed [W-1:0] hdz_o
);
  logic signed [W-1:0] xz, xy;
  logic signed [W-1:0] diff_yx, a_term, b_term, c_term;
  logic signed [W-1:0] dx, dy, dz;

  chaos_fx_mul #(.W(W), .F(F)) i_mul_xz (.a_i(x_i), .b_i(z_i), .p_o(xz));
  chaos_fx_mul #(.W(W), .F(F)) i_mul_xy (.a_i(x_i), .b_i(y_i), .p_o(xy));

  assign diff_yx = y_i - x_i;

  always_comb begin
    if (mode_i == MODE_LORENZ) begin
      a_term = diff_yx <<< A_SH_LZ;
      b_term = z_i <<< B_SH_LZ;
    end else begin
      a_term = diff_yx <<< A_SH_LU;
      b_term = z_i <<< B_SH_LU;
    end
  end

  // c scaling: Lorenz multiplies x, Lü variants multiply y
  always_comb begin
    unique case (mode_i)
      MODE_LORENZ: c_term = x_i <<< C_SH_LZ;
      MODE_LU_A:   c_term = y_i <<< C_SH_HI;
      MODE_LU_B:   c_term = (y_i <<< C_SH_MD) + (y_i <<< C_SH_LO);
      default:     c_term = (y_i <<< C_SH_HI) + (y_i <<< C_SH_LO);
    endcase
  end

  always_comb begin
    dx = a_term;
    dz = xy - b_term;
    if (mode_i == MODE_LORENZ) dy = c_term - y_i - xz;
    else                       dy = c_term - xz;
  end

  assign hdx_o = dx >>> SH;
  assign hdy_o = dy >>> SH;
  assign hdz_o = dz >>> SH;

  p_dx_equal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_i == y_i) |-> (hdx_o == '0));
  p_dz_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_i == '0 && z_i == '0) |-> (hdz_o == '0));
  p_dy_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_i == '0 && y_i == '0) |-> (hdy_o == '0));
  p_mul_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_i == '0) |-> (xz == '0 && xy == '0));
endmodule

// File: rtl/chaos_state_reg.sv
module chaos_state_reg #(
  parameter int unsigned W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic signed [W-1:0] seed_i,
  input  logic signed [W-1:0] step_i,
  output logic signed [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= seed_i;
    else             q_o <= q_o + step_i;
  end
endmodule

// File: rtl/chaos_euler_prng.sv
module chaos_euler_prng
  import chaos_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 init_i,
  input  logic [1:0]           cfg_i,
  input  logic [WIDTH-1:0]     seed_x_i,
  input  logic [WIDTH-1:0]     seed_y_i,
  input  logic [WIDTH-1:0]     seed_z_i,
  output logic [WIDTH-1:0]     x_o,
  output logic [WIDTH-1:0]     y_o,
  output logic [WIDTH-1:0]     z_o,
  output logic [RAND_BITS-1:0] rand_o
);
  logic signed [WIDTH-1:0] seed_v [NVARS];
  logic signed [WIDTH-1:0] step_v [NVARS];
  logic signed [WIDTH-1:0] st_v   [NVARS];
  mode_e                   mode;

  assign mode      = mode_e'(cfg_i);
  assign seed_v[0] = seed_x_i;
  assign seed_v[1] = seed_y_i;
  assign seed_v[2] = seed_z_i;

  chaos_deriv #(.W(WIDTH), .F(FRAC), .SH(STEP_SH)) i_deriv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .x_i    (st_v[0]),
    .y_i    (st_v[1]),
    .z_i    (st_v[2]),
    .hdx_o  (step_v[0]),
    .hdy_o  (step_v[1]),
    .hdz_o  (step_v[2])
  );

  for (genvar i = 0; i < NVARS; i++) begin : g_var
    chaos_state_reg #(.W(WIDTH)) i_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (init_i),
      .seed_i (seed_v[i]),
      .step_i (step_v[i]),
      .q_o    (st_v[i])
    );
    // x in the top byte
    assign rand_o[(NVARS-1-i)*TAP_BITS +: TAP_BITS] = st_v[i][TAP_BITS-1:0];
  end

  assign x_o = st_v[0];
  assign y_o = st_v[1];
  assign z_o = st_v[2];

  p_init_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (x_o == $past(seed_x_i) && y_o == $past(seed_y_i)
                && z_o == $past(seed_z_i)));
  p_zero_fixed_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && x_o == '0 && y_o == '0 && z_o == '0)
    |=> (x_o == '0 && y_o == '0 && z_o == '0));
  p_rand_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (rand_o[RAND_BITS-1 -: TAP_BITS] == $past(seed_x_i[TAP_BITS-1:0])));
endmodule

// File: tb/test_chaos_euler_prng.sv
module test_chaos_euler_prng;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_i = 1'b0;
  logic [1:0]  cfg_i = 2'b00;
  logic [31:0] seed_x_i = '0, seed_y_i = '0, seed_z_i = '0;
  logic [31:0] x_o, y_o, z_o;
  logic [23:0] rand_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [31:0] x, y, z;
    string       tag;
  } exp_t;
  exp_t q[$];
  logic [31:0] mx = '0, my = '0, mz = '0;

  always #4 clk = ~clk;

  chaos_euler_prng i_chaos_euler_prng (
    .clk_i(clk), .rst_ni(rst_ni), .init_i(init_i), .cfg_i(cfg_i),
    .seed_x_i(seed_x_i), .seed_y_i(seed_y_i), .seed_z_i(seed_z_i),
    .x_o(x_o), .y_o(y_o), .z_o(z_o), .rand_o(rand_o)
  );

  // R8: signed product, keep bits [55:24]
  function automatic int fmul(int a, int b);
    longint p = longint'(a) * longint'(b);
    return int'(p[55:24]);
  endfunction

  task automatic model(input logic [1:0] m, inout logic [31:0] x, y, z);
    int xi = int'(x), yi = int'(y), zi = int'(z);
    int ka, kb, kc, dx, dy, dz;
    case (m)
      2'b00: begin ka = 8;  kb = 2; kc = 32; end
      2'b01: begin ka = 32; kb = 4; kc = 16; end
      2'b10: begin ka = 32; kb = 4; kc = 12; end
      default: begin ka = 32; kb = 4; kc = 20; end
    endcase
    dx = ka * (yi - xi);
    dz = fmul(xi, yi) - kb * zi;
    if (m == 2'b00) dy = kc * xi - yi - fmul(xi, zi);
    else            dy = kc * yi - fmul(xi, zi);
    x = 32'(xi + (dx >>> 8));
    y = 32'(yi + (dy >>> 8));
    z = 32'(zi + (dz >>> 8));
  endtask

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit ld, input logic [1:0] m,
                       input logic [31:0] sx, sy, sz, input string tag);
    exp_t e;
    @(negedge clk);
    init_i = ld; cfg_i = m; seed_x_i = sx; seed_y_i = sy; seed_z_i = sz;
    if (ld) begin mx = sx; my = sy; mz = sz; end
    else model(m, mx, my, mz);
    e.x = mx; e.y = my; e.z = mz; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(e.tag, {x_o, y_o, z_o}, {e.x, e.y, e.z});
        check("R9 rand", {72'd0, rand_o}, {72'd0, e.x[7:0], e.y[7:0], e.z[7:0]});
      end
    end
  end

  task automatic run(input logic [1:0] m, input int n, input string tag);
    for (int i = 0; i < n; i++) drive(1'b0, m, '0, '0, '0, tag);
  endtask

  initial begin
    #20;
    check("R1 reset state", {x_o, y_o, z_o}, 96'd0);
    check("R1 reset rand", {72'd0, rand_o}, 96'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    drive(1'b1, 2'b00, 32'h0100_0000, 32'h0080_0000, 32'h0140_0000, "R3 seed");
    run(2'b00, 300, "R6 R4 R5 R2 Lorenz");
    drive(1'b1, 2'b01, 32'hFF40_0000, 32'h0200_0000, 32'h0300_0000, "R3 seed");
    run(2'b01, 300, "R7 c16 R8");
    drive(1'b1, 2'b10, 32'h0123_4567, 32'hFEDC_BA98, 32'h0055_AA55, "R3 seed");
    run(2'b10, 300, "R7 c12 R8");
    drive(1'b1, 2'b11, 32'h0300_0000, 32'h0100_0000, 32'h0A00_0000, "R3 seed");
    run(2'b11, 300, "R7 c20 R8");

    // R10: mode flips every 3 cycles
    for (int i = 0; i < 120; i++) drive(1'b0, 2'((i / 3) % 4), '0, '0, '0, "R10 mode switch");

    // R2 wrap: near full scale
    drive(1'b1, 2'b00, 32'h7F00_0000, 32'h8100_0000, 32'h7FFF_FFFF, "R3 seed big");
    run(2'b00, 40, "R2 wrap Lorenz");
    drive(1'b1, 2'b11, 32'h7E00_0000, 32'h7F00_0000, 32'h8000_0001, "R3 seed big");
    run(2'b11, 40, "R2 R8 wrap");

    // R3: init wins over a running trajectory
    run(2'b01, 5, "R7 pre-init");
    drive(1'b1, 2'b01, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h1234_5678, "R3 mid-run");
    run(2'b01, 10, "R7 post-init");

    // R11: zero fixed point in each mode
    drive(1'b1, 2'b00, '0, '0, '0, "R3 zero seed");
    for (int i = 0; i < 16; i++) drive(1'b0, 2'(i % 4), '0, '0, '0, "R11 zero hold");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule